// File: doc/BRIEF.md
# Debug Control Access Port

This block is a small register set that an external debugger reaches through a simple access-port register bus made of an address, write data, read data and separate write and read strobes. It stays reachable even when memory access protection locks the debugger out of every other path into the chip. Through it the debugger can hold the device in a soft reset, start a full-chip erase, follow the progress of that erase, read the protection state, and read a fixed identification word.

The erase itself is carried out by an external erase engine. This block raises a level request that the engine must serve. The engine answers with a one-cycle done pulse after it has wiped nonvolatile memory, user configuration and RAM. Protection starts from a configuration input sampled while reset is asserted. The only way to clear it is for an erase started here to complete. A soft reset does not clear it, and a stray done pulse does not clear it.

Top module: `dbg_ctrl_port`

## Requirements
- R1: While reset is held and on the first cycle after it, `soft_rst_o`, `erase_req_o` and `bus_rdata` are 0. The soft-reset register (offset 0x000) and the erase status register (offset 0x008) read 0.
- R2: Bit 0 of offset 0x000 is read/write and drives `soft_rst_o` from the cycle after the write. A value of 1 stays in place until 0 is written back, and the register reads back the written bit 0 with all other bits 0.
- R3: A write with bit 0 = 1 to offset 0x004 while no erase is running raises `erase_req_o` in the next cycle, and offset 0x008 then reads 1. A write with bit 0 = 0 has no effect.
- R4: A write of 1 to offset 0x004 while an erase is running is ignored. It does not queue a second erase, and `erase_req_o` drops after the first done pulse and stays low.
- R5: A cycle with `erase_done_i` = 1 while `erase_req_o` = 1 lowers `erase_req_o` in the next cycle, and offset 0x008 then reads 0.
- R6: Bit 0 of offset 0x00C reads 0 while protection is enabled and 1 while it is not. The starting state is `prot_cfg_i` sampled during reset, where 1 means enabled. Later changes of `prot_cfg_i` have no effect.
- R7: Protection goes from enabled to disabled only on a done pulse that ends an erase started here. A done pulse with no erase running, a soft reset, or an erase still in progress leaves it enabled. Once disabled, it stays disabled until the next reset.
- R8: Offset 0x0FC reads the constant 0x02880000. The revision field is bits 31:28 = 0, the continuation code is bits 27:24 = 2, the identity code is bits 23:17 = 0x44, the class is bits 16:13 = 0 and the port number is bits 7:0 = 0. Writes to this offset are ignored.
- R9: Reads of any offset other than 0x000, 0x008, 0x00C and 0x0FC return 0. This includes the write-only offset 0x004 and misaligned offsets. Writes to unmapped offsets change no register.
- R10: `bus_rdata` takes the value of the addressed register in the cycle after `bus_re` = 1 and holds it until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W (32) | Registered read data |
| prot_cfg_i | input | 1 | Protection setting sampled during reset (1 = enabled) |
| erase_done_i | input | 1 | One-cycle pulse from the erase engine when the wipe is finished |
| erase_req_o | output | 1 | Level request to the erase engine, high while an erase runs |
| soft_rst_o | output | 1 | Held soft-reset request to the device |

## Verification
A wrong busy state shows up on `erase_req_o` in the cycle after the faulty write or done pulse. It is also visible on the next status read, one cycle after the read strobe. A wrong protection flag stays in place until reset, so one read of offset 0x00C after each erase event exposes it. Checks of the protection flag are placed after a stray done pulse, during an erase and after a completed erase. Errors in the soft-reset register or in decoding show up on `soft_rst_o` one cycle after the write, or in the read data one cycle after the read. Unmapped writes are therefore followed by reads of the live registers.

// File: rtl/dbg_ctrl_pkg.sv
// Package: shared constants for the debug control access port.
// Holds the register index list, the register offsets and the fields of
// the identification word. Assumes byte offsets fit in 8 bits.
package dbg_ctrl_pkg;

    localparam int DATA_W = 32;
    localparam int NREG   = 5;

    // Register indices used by the decoder and the read mux
    localparam int IDX_RST   = 0;
    localparam int IDX_WIPE  = 1;
    localparam int IDX_WSTAT = 2;
    localparam int IDX_LOCK  = 3;
    localparam int IDX_IDENT = 4;

    // Identification word fields
    localparam logic [3:0] ID_REV   = 4'h0;
    localparam logic [3:0] ID_CONT  = 4'h2;
    localparam logic [6:0] ID_CODE  = 7'h44;
    localparam logic [3:0] ID_CLASS = 4'h0;
    localparam logic [7:0] ID_PORT  = 8'h00;

    // Byte offset of each register index
    function automatic logic [7:0] reg_offset(input int idx);
        case (idx)
            IDX_RST:   reg_offset = 8'h00;
            IDX_WIPE:  reg_offset = 8'h04;
            IDX_WSTAT: reg_offset = 8'h08;
            IDX_LOCK:  reg_offset = 8'h0C;
            default:   reg_offset = 8'hFC;
        endcase
    endfunction

    // Builds the identification word from its fields
    function automatic logic [DATA_W-1:0] ident_word();
        logic [DATA_W-1:0] w;
        w = '0;
        w[31:28] = ID_REV;
        w[27:24] = ID_CONT;
        w[23:17] = ID_CODE;
        w[16:13] = ID_CLASS;
        w[7:0]   = ID_PORT;
        return w;
    endfunction

endpackage

// File: rtl/dbg_ctrl_decode.sv
// Module: address decoder.
// Produces one hit line per register and the matching write strobes.
// Assumes a full-address compare: misaligned offsets hit nothing.
module dbg_ctrl_decode
    import dbg_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output logic [NREG-1:0]   hit_o,
    output logic [NREG-1:0]   wr_o
);

    // One comparator per register
    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign hit_o[i] = (addr_i == ADDR_W'(reg_offset(i)));
        assign wr_o[i]  = we_i & hit_o[i];
    end

endmodule

// File: rtl/dbg_ctrl_wipe.sv
// Module: erase sequencer.
// Holds a level request toward the erase engine from the accepted start
// until the engine's done pulse. Starts that arrive while busy are dropped.
// Done pulses that arrive while idle are ignored.
// Assumes the engine sends exactly one done pulse per request.
module dbg_ctrl_wipe (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o,
    output logic finish_o
);

    typedef enum logic {W_IDLE = 1'b0, W_BUSY = 1'b1} wipe_e;
    wipe_e state_q;

    // Sequencer state: idle -> busy on start, busy -> idle on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            case (state_q)
                W_IDLE:  if (start_i) state_q <= W_BUSY;
                default: if (done_i)  state_q <= W_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q == W_BUSY);
    assign finish_o = busy_o & done_i;

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);
    assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> busy_o);
    assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i) |=> !busy_o);

endmodule

// File: rtl/dbg_ctrl_lock.sv
// Module: protection flag.
// Loads the configured protection state during reset. It clears the flag
// only when an erase completes, and the flag never sets again until reset.
// Assumes finish_i is high only on the done pulse that ends an erase.
module dbg_ctrl_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_i,
    input  logic finish_i,
    output logic locked_o
);

    // Protection flag: sampled in reset, cleared by a completed erase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o <= cfg_i;
        end else if (finish_i) begin
            locked_o <= 1'b0;
        end
    end

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !finish_i) |=> locked_o);
    assert_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |=> !locked_o);
    assert_stay_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_o |=> !locked_o);

endmodule

// File: rtl/dbg_ctrl_port.sv
// Module: debug control access port (top).
// Holds the register file seen by the debugger: the soft-reset hold, the
// erase command and status, the protection status and the identification
// word. Read data is registered and updates only on a read strobe.
// Assumes one-cycle strobes and no write and read to the same register
// in the same cycle.
module dbg_ctrl_port
    import dbg_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              prot_cfg_i,
    input  logic              erase_done_i,
    output logic              erase_req_o,
    output logic              soft_rst_o
);

    logic [NREG-1:0]   hit;
    logic [NREG-1:0]   wr;
    logic              busy;
    logic              finish;
    logic              locked;
    logic [DATA_W-1:0] rd_word;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:1];

    dbg_ctrl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr),
        .we_i   (bus_we),
        .hit_o  (hit),
        .wr_o   (wr)
    );

    dbg_ctrl_wipe u_wipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (wr[IDX_WIPE] & bus_wdata[0]),
        .done_i   (erase_done_i),
        .busy_o   (busy),
        .finish_o (finish)
    );

    dbg_ctrl_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (prot_cfg_i),
        .finish_i (finish),
        .locked_o (locked)
    );

    assign erase_req_o = busy;

    // Soft-reset hold register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_rst_o <= 1'b0;
        end else if (wr[IDX_RST]) begin
            soft_rst_o <= bus_wdata[0];
        end
    end

    // Read mux: the erase command is write-only and unmapped offsets give 0
    always_comb begin
        rd_word = '0;
        if (hit[IDX_RST])   rd_word[0] = soft_rst_o;
        if (hit[IDX_WSTAT]) rd_word[0] = busy;
        if (hit[IDX_LOCK])  rd_word[0] = ~locked;
        if (hit[IDX_IDENT]) rd_word    = ident_word();
    end

    // Registered read data, updated on a read strobe only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_word;
        end
    end

    assert_rst_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr[IDX_RST] |=> soft_rst_o == $past(soft_rst_o));
    assert_rst_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr[IDX_RST] |=> soft_rst_o == $past(bus_wdata[0]));
    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (hit == '0)) |=> bus_rdata == '0);
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/dbg_ctrl_port_bench.sv
`timescale 1ns/1ps
module dbg_ctrl_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        prot_cfg_i = 1'b1;
    logic        erase_done_i = 1'b0;
    logic        erase_req_o;
    logic        soft_rst_o;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dbg_ctrl_port u_dbg_ctrl_port (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_we (bus_we), .bus_re (bus_re), .bus_rdata (bus_rdata),
        .prot_cfg_i (prot_cfg_i), .erase_done_i (erase_done_i),
        .erase_req_o (erase_req_o), .soft_rst_o (soft_rst_o)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'hFC, 32'h0,        32'h02880000, 4'd8},  // R8 ident
        '{1'b0, 8'h00, 32'h0,        32'h0,        4'd1},  // R1 soft reset idle
        '{1'b0, 8'h08, 32'h0,        32'h0,        4'd1},  // R1 erase ready
        '{1'b0, 8'h0C, 32'h0,        32'h0,        4'd6},  // R6 protected
        '{1'b1, 8'h00, 32'hFFFFFFFF, 32'h0,        4'd2},
        '{1'b0, 8'h00, 32'h0,        32'h1,        4'd2},  // R2 readback
        '{1'b1, 8'h00, 32'hFFFFFFFE, 32'h0,        4'd2},
        '{1'b0, 8'h00, 32'h0,        32'h0,        4'd2},  // R2 cleared
        '{1'b1, 8'hFC, 32'h0,        32'h0,        4'd8},
        '{1'b0, 8'hFC, 32'h0,        32'h02880000, 4'd8},  // R8 write ignored
        '{1'b1, 8'h10, 32'hFFFFFFFF, 32'h0,        4'd9},
        '{1'b0, 8'h10, 32'h0,        32'h0,        4'd9},  // R9 unmapped
        '{1'b0, 8'h00, 32'h0,        32'h0,        4'd9},  // R9 no side effect
        '{1'b0, 8'hF8, 32'h0,        32'h0,        4'd9},  // R9
        '{1'b0, 8'h04, 32'h0,        32'h0,        4'd9},  // R9 write-only
        '{1'b0, 8'h03, 32'h0,        32'h0,        4'd9},  // R9 misaligned
        '{1'b1, 8'h04, 32'hFFFFFFFE, 32'h0,        4'd3},
        '{1'b0, 8'h08, 32'h0,        32'h0,        4'd3},  // R3 write 0 no erase
        '{1'b0, 8'h0C, 32'h0,        32'h0,        4'd6}   // R6 still protected
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic cfg);
        prot_cfg_i = cfg;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_done();
        erase_done_i = 1'b1;
        @(negedge clk);
        erase_done_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        prot_cfg_i = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 soft_rst in reset", {31'b0, soft_rst_o}, 32'h0);
        check("R1 erase_req in reset", {31'b0, erase_req_o}, 32'h0);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) begin
                do_write(VECS[i].addr, VECS[i].data);
            end else begin
                do_read(VECS[i].addr, rd);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end
        check("R3 no request after write 0", {31'b0, erase_req_o}, 32'h0);

        // R2: soft reset held across idle cycles
        do_write(8'h00, 32'h1);
        check("R2 soft_rst set", {31'b0, soft_rst_o}, 32'h1);
        repeat (6) @(negedge clk);
        check("R2 soft_rst held", {31'b0, soft_rst_o}, 32'h1);
        do_read(8'h0C, rd);
        check("R7 soft reset keeps protection", rd, 32'h0);
        do_write(8'h00, 32'h0);
        check("R2 soft_rst released", {31'b0, soft_rst_o}, 32'h0);

        // R10: read data holds between strobes
        do_read(8'hFC, rd);
        repeat (3) @(negedge clk);
        check("R10 rdata hold", bus_rdata, 32'h02880000);

        // R7: stray done pulse while idle
        pulse_done();
        do_read(8'h0C, rd);
        check("R7 stray done ignored", rd, 32'h0);

        // R3/R4/R5/R7: full erase
        do_write(8'h04, 32'h1);
        check("R3 request raised", {31'b0, erase_req_o}, 32'h1);
        do_read(8'h08, rd);
        check("R3 status busy", rd, 32'h1);
        do_read(8'h0C, rd);
        check("R7 protected during erase", rd, 32'h0);
        do_write(8'h04, 32'h1);
        check("R4 request still high", {31'b0, erase_req_o}, 32'h1);
        repeat (3) @(negedge clk);
        pulse_done();
        check("R5 request dropped", {31'b0, erase_req_o}, 32'h0);
        do_read(8'h08, rd);
        check("R5 status ready", rd, 32'h0);
        do_read(8'h0C, rd);
        check("R7 protection cleared", rd, 32'h1);
        repeat (4) @(negedge clk);
        check("R4 no queued erase", {31'b0, erase_req_o}, 32'h0);

        // R7: cleared state stays through a later erase and a soft reset
        do_write(8'h00, 32'h1);
        do_write(8'h04, 32'h1);
        pulse_done();
        do_write(8'h00, 32'h0);
        do_read(8'h0C, rd);
        check("R7 stays disabled", rd, 32'h1);

        // R6: protection sampled from configuration in reset
        do_reset(1'b0);
        do_read(8'h0C, rd);
        check("R6 sampled disabled", rd, 32'h1);
        prot_cfg_i = 1'b1;
        repeat (2) @(negedge clk);
        do_read(8'h0C, rd);
        check("R6 cfg change ignored", rd, 32'h1);
        do_reset(1'b1);
        do_read(8'h0C, rd);
        check("R6 sampled enabled", rd, 32'h0);
        check("R1 after second reset", {30'b0, soft_rst_o, erase_req_o}, 32'h0);

        finish_run();
    end

endmodule